// File: doc/BRIEF.md
# Sizable PCI Memory Base Register Pair

This block holds two 32-bit memory base address registers in a PCI-style configuration space. The first register places a control aperture whose size is fixed at 2 MB. The second register places a memory aperture. That aperture is a power of two between 1 MB and 64 MB, and its size comes from a code supplied at boot. Host software finds the size of each aperture by writing all ones to the register and reading it back. The read returns a contiguous run of ones starting at the most significant bit. The lowest one in that run marks the aperture size. Software then writes a suitably aligned base.

In each register, the low four bits are fixed attribute fields. Bit 0 says the aperture is memory space. Bits 2:1 give the placement type. Bit 3 gives the prefetchable attribute. Only the address bits that the aperture size allows can be written. All other bits read back as fixed values. The memory aperture's prefetchable bit and its size both come from boot-time inputs. If the size input changes, the address bits that become read-only are dropped at once.

Top module: `pci_bar_pair`

## Requirements
- R1: After reset, the control register reads 0xEFE00000. The memory register reads 0x00000000, with bit 3 taken from `boot_prefetch`.
- R2: Bits 2:0 read 000 from both registers at all times. Bit 0 = 0 marks a memory aperture. Bits 2:1 = 00 mark a 32-bit base that can be placed anywhere in the 32-bit space.
- R3: Bit 3 of the memory register always equals `boot_prefetch`. Bit 3 of the control register always reads 0.
- R4: After 0xFFFFFFFF is written to the control register (`cfg_sel`=1), it reads 0xFFE00000. Only bits 31:21 are writable there.
- R5: After 0xFFFFFFFF is written to the memory register (`cfg_sel`=0), bits 31:4 read as ones at and above bit L and zeros below it. Here L = 20 + code for `boot_size_code` 0 to 6, and code 7 is treated as 6 (L = 26).
- R6: A write stores only the writable address bits. Afterwards the register reads the written data ANDed with its writable mask, merged with the fixed low bits.
- R7: A write takes effect at the rising edge where `cfg_wr` is high, and it is visible on reads after that edge. Reads are combinational. When `cfg_wr` is low, the stored value does not change.
- R8: A write to one register leaves the other register's read value unchanged.
- R9: When `boot_size_code` changes to a larger aperture, the newly read-only address bits read as zero in the same cycle. They are cleared from storage at the next edge, so returning to the smaller size does not bring them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 1 | Register select: 0 = memory aperture, 1 = control aperture |
| cfg_wr | input | 1 | Write strobe for the selected register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| boot_size_code | input | 3 | Memory aperture size code: 0..6 select 1 MB..64 MB, 7 behaves as 6 |
| boot_prefetch | input | 1 | Prefetchable attribute of the memory aperture |

## Verification
Read data depends combinationally on `cfg_sel`, `boot_size_code`, `boot_prefetch` and the stored bases. A change on those inputs is therefore due in the same cycle, while a write is due only after the rising edge that samples `cfg_wr`. The bench changes every input at the falling edge and samples `cfg_rdata` one time unit later. A write is thus checked half a cycle after the edge that stored it, and a size change is checked both before and after the edge that clears storage. Expected values come from the shift `0xFFFFFFFF << L` computed in the bench, for every size code and both prefetch settings.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;

  localparam int BAR_W   = 32;
  localparam int FLAG_W  = 4;
  localparam int FIELD_W = BAR_W - FLAG_W;

  typedef logic [FIELD_W-1:0] field_t;

  // Which register a configuration access targets.
  typedef enum logic {
    SEL_MEM  = 1'b0,
    SEL_CTRL = 1'b1
  } bar_sel_e;

  // Aperture log2 size from a boot code, clamped to the largest size.
  function automatic int size_log2(input int code, input int min_log2,
                                   input int max_log2);
    int c;
    c = code;
    if (c > max_log2 - min_log2) c = max_log2 - min_log2;
    return min_log2 + c;
  endfunction

  // Writable mask over address bits 31:FLAG_W for an aperture of 2**log2.
  function automatic field_t field_mask(input int log2);
    field_t m;
    for (int i = 0; i < FIELD_W; i++) m[i] = ((i + FLAG_W) >= log2);
    return m;
  endfunction

endpackage

// File: rtl/pci_bar_size_decode.sv
module pci_bar_size_decode
  import pci_bar_pkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int MIN_LOG2 = 20,
  parameter int MAX_LOG2 = 26
) (
  input  logic [CODE_W-1:0] size_code,
  output field_t            wr_mask
);

  int bound;

  always_comb bound = size_log2(int'(size_code), MIN_LOG2, MAX_LOG2);

  // One comparator per address bit: writable at and above the boundary.
  for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
    assign wr_mask[i] = ((i + FLAG_W) >= bound);
  end

endmodule

// File: rtl/pci_bar_store.sv
module pci_bar_store
  import pci_bar_pkg::*;
#(
  parameter field_t RESET_VAL = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  field_t wdata,
  input  field_t mask,
  output field_t q
);

  // Named events for the checks below.
  logic   hold_evt;
  field_t next_q;

  assign hold_evt = !wr_en;

  always_comb begin
    if (wr_en) next_q = wdata & mask;
    else       next_q = q & mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= next_q;
  end

  // R9: bits read-only in a cycle are gone from storage after its edge.
  p_clear_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & ~$past(mask)) == '0));

  // R7: without a strobe, no bit that stays writable changes.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> ((q & $past(mask)) == ($past(q) & $past(mask))));

endmodule

// File: rtl/pci_bar_read_mux.sv
module pci_bar_read_mux
  import pci_bar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  field_t           mem_q,
  input  field_t           mem_mask,
  input  logic             mem_pf,
  input  field_t           ctrl_q,
  input  field_t           ctrl_mask,
  output logic [BAR_W-1:0] rdata
);

  logic [FLAG_W-1:0] mem_flags;
  logic [FLAG_W-1:0] ctrl_flags;

  // bit3 prefetch, bits2:1 type 00 (32-bit anywhere), bit0 memory space.
  assign mem_flags  = {mem_pf, 2'b00, 1'b0};
  assign ctrl_flags = 4'b0000;

  always_comb begin
    if (sel == SEL_CTRL) rdata = {ctrl_q & ctrl_mask, ctrl_flags};
    else                 rdata = {mem_q & mem_mask, mem_flags};
  end

  // R2: memory-space, 32-bit relocatable type on every read.
  p_type_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[2:0] == 3'b000);

  // R3: prefetch bit follows boot input on memory register, 0 on control.
  p_prefetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[3] == ((sel == SEL_MEM) && mem_pf));

endmodule

// File: rtl/pci_bar_pair.sv
module pci_bar_pair
  import pci_bar_pkg::*;
#(
  parameter int          CODE_W        = 3,
  parameter int          MEM_MIN_LOG2  = 20,
  parameter int          MEM_MAX_LOG2  = 26,
  parameter int          CTRL_LOG2     = 21,
  parameter logic [31:0] CTRL_RESET    = 32'hEFE0_0000,
  parameter logic [31:0] MEM_RESET     = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [CODE_W-1:0] boot_size_code,
  input  logic              boot_prefetch
);

  localparam field_t CTRL_MASK  = field_mask(CTRL_LOG2);
  localparam field_t CTRL_RST_F = CTRL_RESET[BAR_W-1:FLAG_W] & CTRL_MASK;
  localparam field_t MEM_RST_F  = MEM_RESET[BAR_W-1:FLAG_W];

  field_t mem_mask;
  field_t mem_q;
  field_t ctrl_q;
  field_t wfield;
  logic   mem_wr_evt;
  logic   ctrl_wr_evt;
  logic   unused_wlow;

  assign wfield      = cfg_wdata[BAR_W-1:FLAG_W];
  assign unused_wlow = ^cfg_wdata[FLAG_W-1:0];
  assign mem_wr_evt  = cfg_wr && (cfg_sel == SEL_MEM);
  assign ctrl_wr_evt = cfg_wr && (cfg_sel == SEL_CTRL);

  pci_bar_size_decode #(
    .CODE_W   (CODE_W),
    .MIN_LOG2 (MEM_MIN_LOG2),
    .MAX_LOG2 (MEM_MAX_LOG2)
  ) u_size (
    .size_code (boot_size_code),
    .wr_mask   (mem_mask)
  );

  pci_bar_store #(.RESET_VAL(MEM_RST_F)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (mem_wr_evt),
    .wdata (wfield),
    .mask  (mem_mask),
    .q     (mem_q)
  );

  pci_bar_store #(.RESET_VAL(CTRL_RST_F)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ctrl_wr_evt),
    .wdata (wfield),
    .mask  (CTRL_MASK),
    .q     (ctrl_q)
  );

  pci_bar_read_mux u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (cfg_sel),
    .mem_q     (mem_q),
    .mem_mask  (mem_mask),
    .mem_pf    (boot_prefetch),
    .ctrl_q    (ctrl_q),
    .ctrl_mask (CTRL_MASK),
    .rdata     (cfg_rdata)
  );

  // R5: the decoded writable run is left-aligned and contiguous.
  p_mask_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(FIELD_W'(~mem_mask + 1'b1)));

  // R6: a control write is visible, masked, on the next cycle's read.
  p_ctrl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_evt |=> ((cfg_sel != SEL_CTRL) ||
                     (cfg_rdata[BAR_W-1:FLAG_W] ==
                      ($past(wfield) & CTRL_MASK))));

  // R8: a memory write leaves the control base untouched.
  p_isolate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_evt |=> $stable(ctrl_q));

endmodule

// File: tb/pci_bar_pair_bench.sv
module pci_bar_pair_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [2:0]  boot_size_code = 3'd0;
  logic        boot_prefetch = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_bar_pair u_pci_bar_pair (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_sel        (cfg_sel),
    .cfg_wr         (cfg_wr),
    .cfg_wdata      (cfg_wdata),
    .cfg_rdata      (cfg_rdata),
    .boot_size_code (boot_size_code),
    .boot_prefetch  (boot_prefetch)
  );

  function automatic logic [31:0] mem_expect(int code, logic pf,
                                             logic [31:0] d);
    int l;
    l = 20 + ((code > 6) ? 6 : code);
    return (d & (32'hFFFF_FFFF << l)) | {28'd0, pf, 3'b000};
  endfunction

  function automatic logic [31:0] ctrl_expect(logic [31:0] d);
    return d & 32'hFFE0_0000;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic do_write(logic sel, logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = ~d;
  endtask

  task automatic do_read(logic sel, output logic [31:0] v);
    cfg_sel = sel;
    #1;
    v = cfg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  logic [31:0] pats [5];
  initial begin
    logic [31:0] v;
    logic [31:0] ctrl_now;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5;
    pats[2] = 32'h5A5A_5A5F; pats[3] = 32'h1234_5678;
    pats[4] = 32'h0000_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    do_read(1'b1, v); check("R1 ctrl reset", v, 32'hEFE0_0000);
    do_read(1'b0, v); check("R1 mem reset", v, 32'h0000_0000);
    boot_prefetch = 1'b1;
    do_read(1'b0, v); check("R1/R3 mem reset pf", v, 32'h0000_0008);
    boot_prefetch = 1'b0;

    // R4: control size discovery
    do_write(1'b1, 32'hFFFF_FFFF);
    do_read(1'b1, v); check("R4 ctrl all ones", v, 32'hFFE0_0000);
    check("R3 ctrl pbit", {31'd0, v[3]}, 32'd0);
    ctrl_now = v;

    // R5/R6/R2/R3/R8: sweep every size code, both prefetch values
    for (int c = 0; c < 8; c++) begin
      for (int pf = 0; pf < 2; pf++) begin
        boot_size_code = 3'(c);
        boot_prefetch  = 1'(pf);
        for (int p = 0; p < 5; p++) begin
          do_write(1'b0, pats[p]);
          do_read(1'b0, v);
          check(p == 0 ? "R5 mem size discovery" : "R6 mem masked write",
                v, mem_expect(c, 1'(pf), pats[p]));
          check("R2 mem type bits", {29'd0, v[2:0]}, 32'd0);
          do_read(1'b1, v);
          check("R8 ctrl untouched", v, ctrl_now);
        end
      end
    end

    // R6/R8: control patterns, memory unaffected
    boot_size_code = 3'd2; boot_prefetch = 1'b0;
    do_write(1'b0, 32'hDEAD_BEEF);
    for (int p = 0; p < 5; p++) begin
      do_write(1'b1, pats[p]);
      do_read(1'b1, v); check("R6 ctrl masked write", v, ctrl_expect(pats[p]));
      check("R2 ctrl type bits", {29'd0, v[2:0]}, 32'd0);
      do_read(1'b0, v);
      check("R8 mem untouched", v, mem_expect(2, 1'b0, 32'hDEAD_BEEF));
    end

    // R7: strobe low for several edges leaves both values unchanged
    do_write(1'b1, 32'h8760_0000);
    @(negedge clk); cfg_sel = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    do_read(1'b1, v); check("R7 ctrl hold", v, 32'h8760_0000);
    cfg_sel = 1'b0; repeat (2) @(negedge clk);
    do_read(1'b0, v);
    check("R7 mem hold", v, mem_expect(2, 1'b0, 32'hDEAD_BEEF));

    // R9: enlarging the aperture drops low bits at once and for good
    boot_size_code = 3'd0;
    do_write(1'b0, 32'hFFFF_FFFF);
    do_read(1'b0, v); check("R9 before resize", v, 32'hFFF0_0000);
    @(negedge clk); boot_size_code = 3'd6;
    do_read(1'b0, v); check("R9 immediate mask", v, 32'hFC00_0000);
    @(negedge clk); boot_size_code = 3'd0;
    do_read(1'b0, v); check("R9 bits cleared", v, 32'hFC00_0000);

    // R1: reset restores both registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_read(1'b1, v); check("R1 ctrl re-reset", v, 32'hEFE0_0000);
    do_read(1'b0, v); check("R1 mem re-reset", v, 32'h0000_0000);

    finish_run();
  end

endmodule